// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by looking up one entry in a page table that sits in ordinary memory. The upper bits of the virtual address select a page. The lower bits give the byte position inside that page. The block reads the selected entry through a simple request/acknowledge memory port. It checks whether the page is resident and whether the access kind is permitted. It then forms the physical address by placing the entry's frame number above the unchanged in-page offset. No adder and no limit compare sit on the address path.

On a successful access, the block marks the entry as referenced, and for stores also as modified. It writes the entry back to the same table slot before answering, but only when a bit actually changed. Non-resident pages and forbidden access kinds are reported as two distinct fault codes. One translation is in flight at a time, and its answer stays on the response port until the requester takes it.

Top module: `vpage_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: For an accepted request, the block issues exactly one memory read (`mem_we`=0) at address `tbl_base + vpn`, modulo 2^MA_W, where vpn is `req_vaddr[VA_W-1:OFF_W]` and OFF_W = log2(PAGE_BYTES).
- R3: Entry layout, LSB first: frame number in bits [PFN_W-1:0], then read-allowed at bit PFN_W, write-allowed at PFN_W+1, execute-allowed at PFN_W+2, resident at PFN_W+3, referenced at PFN_W+4, modified at PFN_W+5. On success `rsp_code`=0, `rsp_fault`=0 and `rsp_paddr` = {frame, vaddr[OFF_W-1:0]}.
- R4: An entry whose resident bit is 0 gives `rsp_code`=1 (page fault) whatever its permissions, with `rsp_fault`=1, `rsp_paddr`=0 and no memory write.
- R5: Access kinds are `req_acc` 0 = load (needs read-allowed), 1 = store (needs write-allowed) and 2 = fetch (needs execute-allowed). Kind 3 is never allowed. A resident entry lacking the needed permission gives `rsp_code`=2 (protection fault), `rsp_fault`=1, `rsp_paddr`=0 and no memory write.
- R6: A successful access sets the referenced bit, and a store also sets the modified bit. If this changes the entry, the updated entry is written (`mem_we`=1) to the same address and the write is acknowledged before `rsp_valid` rises.
- R7: If a successful access changes no bit of the entry, no memory write is issued.
- R8: `rsp_valid`, `rsp_code`, `rsp_fault` and `rsp_paddr` hold steady until `rsp_ready` is sampled high. `req_ready` stays 0 from acceptance until that handshake, and is 1 in the following cycle.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack` is sampled high. The response for a read is taken from `mem_rdata` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | MA_W | Word address of page table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 2 | 0 success, 1 page fault, 2 protection fault |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| mem_req | output | 1 | Table memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MA_W | Table memory word address |
| mem_wdata | output | ENT_W | Entry being written back |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | ENT_W | Entry read, valid with mem_ack |

## Verification
The hardest case to reach from the ports is the write-back interleaving. Here a read acknowledgement is followed at once by a write that must finish before the response appears, and the memory stalls both halves. The bench's memory responder inserts a programmable number of wait cycles before each acknowledge. It also keeps its own write log, so the bench can confirm at the moment `rsp_valid` rises that the write has already landed at the entry's address. Entries are preloaded so that the same page is hit twice, first with the referenced or modified bit clear and then with it already set. This exercises both the write and the skipped write. A table base near the top of the address range forces the entry address to wrap.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        PX_IDLE  = 2'd0,
        PX_READ  = 2'd1,
        PX_WRITE = 2'd2,
        PX_RESP  = 2'd3
    } px_state_e;

    // access kinds
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // result codes
    localparam logic [1:0] RES_OK     = 2'd0;
    localparam logic [1:0] RES_ABSENT = 2'd1;
    localparam logic [1:0] RES_DENIED = 2'd2;

    // entry field offsets above the frame number
    localparam int FLD_RD    = 0;
    localparam int FLD_WR    = 1;
    localparam int FLD_EX    = 2;
    localparam int FLD_RES   = 3;
    localparam int FLD_REF   = 4;
    localparam int FLD_MOD   = 5;
    localparam int FLD_COUNT = 6;

endpackage

// File: rtl/pgx_split.sv
module pgx_split #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 10,
    parameter int MA_W  = 16
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [MA_W-1:0]  base,
    output logic [OFF_W-1:0] off,
    output logic [MA_W-1:0]  ent_addr
);
    localparam int VPN_W = VA_W - OFF_W;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn      = vaddr[VA_W-1:OFF_W];
        off      = vaddr[OFF_W-1:0];
        ent_addr = base + MA_W'(vpn);
    end
endmodule

// File: rtl/pgx_judge.sv
module pgx_judge
    import pgx_pkg::*;
#(
    parameter int PFN_W = 10,
    parameter int OFF_W = 10
) (
    input  logic [PFN_W+FLD_COUNT-1:0] ent,
    input  logic [1:0]                 acc,
    input  logic [OFF_W-1:0]           off,
    output logic [1:0]                 code,
    output logic [PFN_W+FLD_COUNT-1:0] upd_ent,
    output logic                       need_wb,
    output logic [PFN_W+OFF_W-1:0]     paddr
);
    logic allowed;

    always_comb begin
        case (acc)
            ACC_LOAD:  allowed = ent[PFN_W+FLD_RD];
            ACC_STORE: allowed = ent[PFN_W+FLD_WR];
            ACC_FETCH: allowed = ent[PFN_W+FLD_EX];
            default:   allowed = 1'b0;
        endcase

        if (!ent[PFN_W+FLD_RES])  code = RES_ABSENT;
        else if (!allowed)        code = RES_DENIED;
        else                      code = RES_OK;

        upd_ent = ent;
        if (code == RES_OK) begin
            upd_ent[PFN_W+FLD_REF] = 1'b1;
            if (acc == ACC_STORE) upd_ent[PFN_W+FLD_MOD] = 1'b1;
        end
        need_wb = (code == RES_OK) && (upd_ent != ent);
        paddr   = (code == RES_OK) ? {ent[PFN_W-1:0], off} : '0;
    end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
    import pgx_pkg::*;
#(
    parameter int VA_W       = 16,
    parameter int PA_W       = 20,
    parameter int PAGE_BYTES = 1024,
    parameter int MA_W       = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [MA_W-1:0]                       tbl_base,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [VA_W-1:0]                       req_vaddr,
    input  logic [1:0]                            req_acc,
    output logic                                  rsp_valid,
    input  logic                                  rsp_ready,
    output logic                                  rsp_fault,
    output logic [1:0]                            rsp_code,
    output logic [PA_W-1:0]                       rsp_paddr,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [MA_W-1:0]                       mem_addr,
    output logic [PA_W-$clog2(PAGE_BYTES)+5:0]    mem_wdata,
    input  logic                                  mem_ack,
    input  logic [PA_W-$clog2(PAGE_BYTES)+5:0]    mem_rdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PFN_W = PA_W - OFF_W;
    localparam int ENT_W = PFN_W + FLD_COUNT;

    if (PAGE_BYTES < 512 || PAGE_BYTES > 16384 || (1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
        $error("page size must be a power of two from 512 to 16384");
    end

    typedef struct packed {
        px_state_e        st;
        logic [VA_W-1:0]  va;
        logic [1:0]       acc;
        logic [ENT_W-1:0] ent;
        logic [1:0]       code;
        logic [PA_W-1:0]  pa;
    } regs_t;

    regs_t r_q, r_d;

    logic [OFF_W-1:0] off_w;
    logic [MA_W-1:0]  ent_addr_w;
    logic [1:0]       code_w;
    logic [ENT_W-1:0] upd_w;
    logic             wb_w;
    logic [PA_W-1:0]  pa_w;

    pgx_split #(.VA_W(VA_W), .OFF_W(OFF_W), .MA_W(MA_W)) i_split (
        .vaddr    (r_q.va),
        .base     (tbl_base),
        .off      (off_w),
        .ent_addr (ent_addr_w)
    );

    pgx_judge #(.PFN_W(PFN_W), .OFF_W(OFF_W)) i_judge (
        .ent     (mem_rdata),
        .acc     (r_q.acc),
        .off     (off_w),
        .code    (code_w),
        .upd_ent (upd_w),
        .need_wb (wb_w),
        .paddr   (pa_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PX_IDLE: begin
                if (req_valid) begin
                    r_d.va  = req_vaddr;
                    r_d.acc = req_acc;
                    r_d.st  = PX_READ;
                end
            end
            PX_READ: begin
                if (mem_ack) begin
                    r_d.ent  = upd_w;
                    r_d.code = code_w;
                    r_d.pa   = pa_w;
                    r_d.st   = wb_w ? PX_WRITE : PX_RESP;
                end
            end
            PX_WRITE: begin
                if (mem_ack) r_d.st = PX_RESP;
            end
            PX_RESP: begin
                if (rsp_ready) r_d.st = PX_IDLE;
            end
            default: r_d.st = PX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PX_IDLE, va: '0, acc: '0, ent: '0, code: '0, pa: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready = (r_q.st == PX_IDLE);
        mem_req   = (r_q.st == PX_READ) || (r_q.st == PX_WRITE);
        mem_we    = (r_q.st == PX_WRITE);
        mem_addr  = ent_addr_w;
        mem_wdata = r_q.ent;
        rsp_valid = (r_q.st == PX_RESP);
        rsp_code  = r_q.code;
        rsp_fault = (r_q.code != RES_OK);
        rsp_paddr = r_q.pa;
    end
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
    parameter int PA_W  = 20,
    parameter int MA_W  = 16,
    parameter int ENT_W = 16,
    parameter int PFN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_fault,
    input logic [1:0]       rsp_code,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             mem_req,
    input logic             mem_we,
    input logic [MA_W-1:0]  mem_addr,
    input logic [ENT_W-1:0] mem_wdata,
    input logic             mem_ack
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R9

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_fault) && $stable(rsp_paddr)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> !req_ready); // R8

    AST_WB_BEFORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req); // R6

    AST_WB_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_ack) && $past(mem_req) && $stable(mem_addr)); // R6

    AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[PFN_W+4] && mem_wdata[PFN_W+3]); // R6

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0); // R4

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'd3); // R5
endmodule

bind vpage_xlate pgx_chk #(
    .PA_W(PA_W), .MA_W(MA_W), .ENT_W(ENT_W), .PFN_W(PFN_W)
) i_pgx_chk (.*);

// File: tb/test_vpage_xlate.sv
`timescale 1ns/1ps
module test_vpage_xlate;
    localparam int VA_W = 16;
    localparam int PA_W = 20;
    localparam int PAGE_BYTES = 1024;
    localparam int MA_W = 16;
    localparam int ENT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MA_W-1:0] tbl_base = 16'h0100;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0] req_acc = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic rsp_fault;
    logic [1:0] rsp_code;
    logic [PA_W-1:0] rsp_paddr;
    logic mem_req, mem_we;
    logic [MA_W-1:0] mem_addr;
    logic [ENT_W-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [ENT_W-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    vpage_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES), .MA_W(MA_W)) i_vpage_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit busy = 1'b0;

    logic [ENT_W-1:0] mem [logic [15:0]];
    logic [ENT_W-1:0] mdl [logic [15:0]];
    int mem_lat = 0;
    int lat_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [15:0] rd_addr = '0;
    logic [15:0] wr_addr = '0;
    logic [ENT_W-1:0] wr_data = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ent(input logic [15:0] a, input logic [ENT_W-1:0] v);
        mem[a] = v;
        mdl[a] = v;
    endtask

    // memory responder with programmable wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    lat_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_cnt++;
                        wr_addr = mem_addr;
                        wr_data = mem_wdata;
                    end else begin
                        rd_cnt++;
                        rd_addr = mem_addr;
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : '0;
                    end
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    // idle monitor, every clock
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !busy && !done) begin
                chk("R1 idle rsp_valid", 32'(rsp_valid), 32'd0);
                chk("R1 idle mem_req", 32'(mem_req), 32'd0);
            end
        end
    end

    // one translation, compared against a behavioural model
    task automatic xl(input logic [15:0] va, input logic [1:0] acc, input int lat, input int hold);
        logic [15:0] ea;
        logic [ENT_W-1:0] e, ne;
        logic [1:0] ecode;
        logic [PA_W-1:0] epa;
        bit perm, wb;
        int rd0, wr0, cyc;
        ea = tbl_base + 16'(va[15:10]);
        e = mdl.exists(ea) ? mdl[ea] : '0;
        perm = (acc == 2'd0 && e[10]) || (acc == 2'd1 && e[11]) || (acc == 2'd2 && e[12]);
        ne = e;
        wb = 1'b0;
        if (!e[13]) begin
            ecode = 2'd1; epa = '0;
        end else if (!perm) begin
            ecode = 2'd2; epa = '0;
        end else begin
            ecode = 2'd0;
            epa = {e[9:0], va[9:0]};
            ne[14] = 1'b1;
            if (acc == 2'd1) ne[15] = 1'b1;
            wb = (ne != e);
            mdl[ea] = ne;
        end
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        mem_lat = lat;
        busy = 1'b1;
        chk("R8 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 not ready while busy", 32'(req_ready), 32'd0);
        cyc = 0;
        while (!rsp_valid && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 response arrives", 32'(rsp_valid), 32'd1);
        chk("R2 one read", 32'(rd_cnt - rd0), 32'd1);
        chk("R2 entry address", 32'(rd_addr), 32'(ea));
        chk("R3 R4 R5 code", 32'(rsp_code), 32'(ecode));
        chk("R4 R5 fault flag", 32'(rsp_fault), 32'(ecode != 2'd0));
        chk("R3 physical address", 32'(rsp_paddr), 32'(epa));
        chk("R6 R7 write count", 32'(wr_cnt - wr0), 32'(wb));
        if (wb) begin
            chk("R6 write address", 32'(wr_addr), 32'(ea));
            chk("R6 write data", 32'(wr_data), 32'(ne));
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R8 held valid", 32'(rsp_valid), 32'd1);
            chk("R8 held code", 32'(rsp_code), 32'(ecode));
            chk("R8 held address", 32'(rsp_paddr), 32'(epa));
            chk("R8 held not ready", 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 released", 32'(rsp_valid), 32'd0);
        chk("R8 ready again", 32'(req_ready), 32'd1);
        busy = 1'b0;
    endtask

    initial begin
        // entry: [9:0] frame, 10 rd, 11 wr, 12 ex, 13 resident, 14 ref, 15 mod
        set_ent(16'h0100 + 16'd3,  16'h2000 | 16'h0400 | 16'h0155);   // R only
        set_ent(16'h0100 + 16'd7,  16'h2000 | 16'h0C00 | 16'h03AA);   // R,W
        set_ent(16'h0100 + 16'd9,  16'h2000 | 16'h0800 | 16'h0012);   // W only
        set_ent(16'h0100 + 16'd12, 16'h2000 | 16'h1000 | 16'h0077);   // X only
        set_ent(16'h0100 + 16'd20, 16'h1C00 | 16'h0200);              // not resident, all perms
        set_ent(16'h0100 + 16'd21, 16'h0000);                         // not resident, none
        set_ent(16'h0100 + 16'd63, 16'h2000 | 16'h1C00 | 16'h03FF);   // all perms, top page
        set_ent(16'h000C,          16'h2000 | 16'h0400 | 16'h0081);   // wrapped slot

        repeat (3) @(negedge clk);
        chk("R1 reset req_ready", 32'(req_ready), 32'd1);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;

        xl({6'd3, 10'h123},  2'd0, 0, 0);   // R3 R6 load sets ref
        xl({6'd3, 10'h3FF},  2'd0, 2, 1);   // R7 no change, no write
        xl({6'd7, 10'h001},  2'd1, 3, 3);   // R6 store sets ref+mod, stalls
        xl({6'd7, 10'h200},  2'd1, 1, 0);   // R7
        xl({6'd7, 10'h000},  2'd0, 0, 2);   // R7 load on modified page
        xl({6'd9, 10'h044},  2'd0, 0, 0);   // R5 load without read permission
        xl({6'd9, 10'h044},  2'd1, 2, 0);   // R6 store allowed
        xl({6'd12, 10'h0F0}, 2'd2, 0, 0);   // R5 fetch allowed
        xl({6'd12, 10'h0F0}, 2'd0, 0, 0);   // R5 load denied
        xl({6'd63, 10'h2AA}, 2'd3, 1, 0);   // R5 kind 3 never allowed
        xl({6'd63, 10'h2AA}, 2'd2, 4, 2);   // R3 top page
        xl({6'd20, 10'h010}, 2'd0, 0, 1);   // R4 not resident
        xl({6'd21, 10'h010}, 2'd1, 2, 0);   // R4 priority over permission
        tbl_base = 16'hFFF8;
        xl({6'd20, 10'h155}, 2'd0, 1, 0);   // R2 address wraps to 000C
        tbl_base = 16'h0100;

        foreach (mdl[a]) chk("R6 final table contents", 32'(mem[a]), 32'(mdl[a]));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule